// File: doc/BRIEF.md
# Extended Address Sequence Controller

This block sits next to a simple CPU pipeline and carries out the instruction that opens an extended segment and register sequence. When a valid encoding of that instruction is presented on the decode strobe, the block latches an 8-bit segment and loads a countdown with the sequence length, which is 1 to 4. The segment comes from the low byte of a register, in the two-byte form, or from an immediate byte, in the four-byte form. The countdown then drops by one for each instruction that the pipeline retires.

While the countdown is nonzero, several overrides apply. Long and indirect data accesses take the latched segment as address bits 23:16 in place of the page-formed address. Register and bit accesses are steered to the extended special-register space. Standard interrupts, peripheral event transfers and low-class traps are held off. A high-class trap ends the sequence at once. The overrides apply from the cycle after decode, so the next instruction is already affected.

Top module: `extseq_ctrl`

## Requirements
- R1: The register form is recognised when byte 0 (`instr_bytes[7:0]`) is 0xDC and byte 1 bits 7:6 are 2'b10. Its segment is `reg_rdata[7:0]`. `src_reg` always shows byte 1 bits 3:0.
- R2: The immediate form is recognised when byte 0 is 0xD7, byte 1 bits 7:6 are 2'b10, byte 1 bits 3:0 are 0 and byte 3 is 0x00. Its segment is byte 2. Any other strobed encoding leaves the state unchanged.
- R3: A recognised instruction loads the countdown with byte 1 bits 5:4 plus one. `seq_active` is high from the next cycle.
- R4: Each `retire` pulse while the countdown is nonzero lowers it by one. On the cycle it reaches zero, every override and mask is released.
- R5: While the sequence is active and `acc_long` is high, `data_addr` is {latched segment, `acc_ofs`}. Otherwise it equals `page_addr`.
- R6: `ext_sfr` is high exactly while the sequence is active.
- R7: `int_pass` equals `int_req` while the sequence is inactive and is zero while it is active. The bits are: bit 0 standard interrupt, bit 1 peripheral event transfer, bit 2 class A trap.
- R8: A `trap_b` pulse forces the countdown to zero on the next cycle. This holds even when a recognised instruction is strobed in the same cycle.
- R9: A recognised instruction decoded during an active sequence reloads both the length and the segment. A load in the same cycle as `retire` takes the new length undecremented.
- R10: A synchronous reset clears the countdown, which deasserts `seq_active`, `ext_sfr` and all masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Decode strobe for `instr_bytes` |
| instr_bytes | input | 32 | Instruction bytes, byte 0 in bits 7:0 |
| reg_rdata | input | 16 | Value read from the register named by `src_reg` |
| src_reg | output | 4 | Source register number from byte 1 |
| retire | input | 1 | Pulse per completed instruction |
| trap_b | input | 1 | High-class trap condition |
| int_req | input | 3 | Interrupt, event-transfer and class A trap requests |
| int_pass | output | 3 | Requests let through to the pipeline |
| acc_long | input | 1 | Current data access is long or indirect |
| acc_ofs | input | 16 | Offset of the current data access |
| page_addr | input | 24 | Page-formed data address |
| data_addr | output | 24 | Data address in use |
| ext_sfr | output | 1 | Extended special-register space selected |
| seq_active | output | 1 | Sequence countdown nonzero |

## Verification
On every cycle, the assertions check several rules. The countdown stays in range. It drops by exactly one per retire. A high-class trap empties it, and a recognised encoding starts a sequence. The mask, address selection and space select follow the active state. Only the bench scenarios show the exact segment value taken from each form, with a sweep over both forms, every length and several segment values. The same holds for release on the precise retire, reload of a running sequence, and rejection of malformed encodings.

// File: rtl/extseq_pkg.sv
package extseq_pkg;
   localparam logic [7:0] OPC_REG  = 8'hDC;
   localparam logic [7:0] OPC_IMM  = 8'hD7;
   localparam logic [1:0] SUB_TAG  = 2'b10;
   localparam int         NUM_SRC  = 3;

   typedef enum logic [1:0] {
      FORM_NONE = 2'd0,
      FORM_REG  = 2'd1,
      FORM_IMM  = 2'd2
   } form_e;
endpackage

// File: rtl/extseq_decode.sv
module extseq_decode
   import extseq_pkg::*;
#(
   parameter int SEG_W = 8,
   parameter int CNT_W = 3
) (
   input  logic             valid,
   input  logic [31:0]      bytes,
   input  logic [15:0]      rdata,
   output logic             hit,
   output logic [CNT_W-1:0] len,
   output logic [SEG_W-1:0] seg,
   output logic [3:0]       rnum
);
   logic [7:0] b0, b1, b2, b3;
   form_e      form;

   assign b0   = bytes[7:0];
   assign b1   = bytes[15:8];
   assign b2   = bytes[23:16];
   assign b3   = bytes[31:24];
   assign rnum = b1[3:0];

   always_comb begin
      form = FORM_NONE;
      if (valid && b1[7:6] == SUB_TAG) begin
         if (b0 == OPC_REG)
            form = FORM_REG;
         else if (b0 == OPC_IMM && b1[3:0] == 4'h0 && b3 == 8'h00)
            form = FORM_IMM;
      end
   end

   assign hit = (form != FORM_NONE);
   assign len = CNT_W'(b1[5:4]) + CNT_W'(1);
   assign seg = (form == FORM_IMM) ? b2[SEG_W-1:0] : rdata[SEG_W-1:0];
endmodule

// File: rtl/extseq_count.sv
module extseq_count #(
   parameter int SEG_W = 8,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   input  logic [SEG_W-1:0] load_seg,
   input  logic             retire,
   input  logic             abort,
   output logic [CNT_W-1:0] cnt,
   output logic [SEG_W-1:0] seg,
   output logic             active
);
   always_ff @(posedge clk) begin
      if (rst || abort) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_len;
      end else if (retire && cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         seg <= '0;
      else if (load && !abort)
         seg <= load_seg;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/extseq_addr.sv
module extseq_addr #(
   parameter int SEG_W = 8,
   parameter int OFS_W = 16,
   parameter int N_SRC = 3,
   parameter logic [N_SRC-1:0] MASKABLE = '1
) (
   input  logic                   active,
   input  logic                   acc_long,
   input  logic [SEG_W-1:0]       seg,
   input  logic [OFS_W-1:0]       ofs,
   input  logic [SEG_W+OFS_W-1:0] page_addr,
   input  logic [N_SRC-1:0]       req,
   output logic [SEG_W+OFS_W-1:0] addr,
   output logic [N_SRC-1:0]       pass
);
   assign addr = (active && acc_long) ? {seg, ofs} : page_addr;

   for (genvar i = 0; i < N_SRC; i++) begin : g_gate
      if (MASKABLE[i]) begin : g_mask
         assign pass[i] = req[i] & ~active;
      end else begin : g_thru
         assign pass[i] = req[i];
      end
   end
endmodule

// File: rtl/extseq_ctrl.sv
module extseq_ctrl
   import extseq_pkg::*;
#(
   parameter int SEG_W   = 8,
   parameter int OFS_W   = 16,
   parameter int MAX_LEN = 4,
   localparam int CNT_W  = $clog2(MAX_LEN + 1),
   localparam int ADDR_W = SEG_W + OFS_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 instr_valid,
   input  logic [31:0]          instr_bytes,
   input  logic [15:0]          reg_rdata,
   output logic [3:0]           src_reg,
   input  logic                 retire,
   input  logic                 trap_b,
   input  logic [NUM_SRC-1:0]   int_req,
   output logic [NUM_SRC-1:0]   int_pass,
   input  logic                 acc_long,
   input  logic [OFS_W-1:0]     acc_ofs,
   input  logic [ADDR_W-1:0]    page_addr,
   output logic [ADDR_W-1:0]    data_addr,
   output logic                 ext_sfr,
   output logic                 seq_active
);
   initial begin
      assert (SEG_W == 8) else $error("segment must be one immediate byte");
      assert (MAX_LEN == 4) else $error("length field encodes 1..4");
   end

   logic             dec_hit;
   logic [CNT_W-1:0] dec_len;
   logic [SEG_W-1:0] dec_seg;
   logic [CNT_W-1:0] cnt;
   logic [SEG_W-1:0] cur_seg;
   logic             active;

   extseq_decode #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_dec (
      .valid(instr_valid), .bytes(instr_bytes), .rdata(reg_rdata),
      .hit(dec_hit), .len(dec_len), .seg(dec_seg), .rnum(src_reg)
   );

   extseq_count #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(dec_hit), .load_len(dec_len),
      .load_seg(dec_seg), .retire(retire), .abort(trap_b),
      .cnt(cnt), .seg(cur_seg), .active(active)
   );

   extseq_addr #(.SEG_W(SEG_W), .OFS_W(OFS_W), .N_SRC(NUM_SRC)) u_addr (
      .active(active), .acc_long(acc_long), .seg(cur_seg), .ofs(acc_ofs),
      .page_addr(page_addr), .req(int_req), .addr(data_addr), .pass(int_pass)
   );

   assign ext_sfr    = active;
   assign seq_active = active;
endmodule

// File: rtl/extseq_chk.sv
module extseq_chk #(
   parameter int MAX_LEN = 4,
   parameter int CNT_W   = 3,
   parameter int ADDR_W  = 24
) (
   input logic              clk,
   input logic              rst,
   input logic              instr_valid,
   input logic [31:0]       instr_bytes,
   input logic              retire,
   input logic              trap_b,
   input logic [2:0]        int_req,
   input logic [2:0]        int_pass,
   input logic              acc_long,
   input logic [ADDR_W-1:0] page_addr,
   input logic [ADDR_W-1:0] data_addr,
   input logic              ext_sfr,
   input logic              seq_active,
   input logic [CNT_W-1:0]  cnt
);
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(MAX_LEN)); // R3
   AST_REG_START: assert property (@(posedge clk) disable iff (rst)
      instr_valid && instr_bytes[7:0] == 8'hDC && instr_bytes[15:14] == 2'b10 && !trap_b
      |=> seq_active); // R1
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      seq_active && retire && !instr_valid && !trap_b |=> cnt == $past(cnt) - CNT_W'(1)); // R4
   AST_TRAP_CLEAR: assert property (@(posedge clk) disable iff (rst)
      trap_b |=> !seq_active); // R8
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
      seq_active |-> int_pass == 3'b000); // R7
   AST_PAGE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(seq_active && acc_long) |-> data_addr == page_addr); // R5
   AST_SPACE_SEL: assert property (@(posedge clk) disable iff (rst)
      ext_sfr == (cnt != '0)); // R6
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> !seq_active && int_pass == int_req); // R10
endmodule

bind extseq_ctrl extseq_chk #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_bytes(instr_bytes),
   .retire(retire), .trap_b(trap_b), .int_req(int_req), .int_pass(int_pass),
   .acc_long(acc_long), .page_addr(page_addr), .data_addr(data_addr),
   .ext_sfr(ext_sfr), .seq_active(seq_active), .cnt(cnt)
);

// File: tb/extseq_ctrl_tb.sv
`timescale 1ns/1ps
module extseq_ctrl_tb;
   logic        clk = 0;
   logic        rst;
   logic        instr_valid;
   logic [31:0] instr_bytes;
   logic [15:0] reg_rdata;
   logic [3:0]  src_reg;
   logic        retire, trap_b;
   logic [2:0]  int_req, int_pass;
   logic        acc_long;
   logic [15:0] acc_ofs;
   logic [23:0] page_addr, data_addr;
   logic        ext_sfr, seq_active;

   int n_cmp = 0, n_bad = 0;
   int m_cnt;
   logic [7:0] m_seg;

   always #4 clk = ~clk;

   extseq_ctrl u_dut (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_bytes(instr_bytes),
      .reg_rdata(reg_rdata), .src_reg(src_reg), .retire(retire), .trap_b(trap_b),
      .int_req(int_req), .int_pass(int_pass), .acc_long(acc_long), .acc_ofs(acc_ofs),
      .page_addr(page_addr), .data_addr(data_addr), .ext_sfr(ext_sfr),
      .seq_active(seq_active)
   );

   function automatic logic [31:0] mk_reg(int len, logic [3:0] rn);
      return {16'h0000, 2'b10, 2'(len - 1), rn, 8'hDC};
   endfunction
   function automatic logic [31:0] mk_imm(int len, logic [7:0] sg);
      return {8'h00, sg, 2'b10, 2'(len - 1), 4'h0, 8'hD7};
   endfunction

   task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(string req);
      logic act_e;
      act_e = (m_cnt != 0);
      cmp({req, " R6 active"}, 32'(seq_active), 32'(act_e));
      cmp({req, " R6 space"}, 32'(ext_sfr), 32'(act_e));
      cmp({req, " R7 mask"}, 32'(int_pass), act_e ? 32'h0 : 32'h7);
      cmp({req, " R5 addr"}, 32'(data_addr),
          act_e ? {8'h00, m_seg, acc_ofs} : {8'h00, page_addr});
   endtask

   // one clock: model next state from applied inputs, then return to idle inputs
   task automatic step(logic v, logic [31:0] b, logic [15:0] rd, logic ret, logic tb,
                       logic exp_hit, int exp_len, logic [7:0] exp_seg);
      instr_valid = v; instr_bytes = b; reg_rdata = rd; retire = ret; trap_b = tb;
      @(posedge clk);
      #1;
      if (tb) m_cnt = 0;
      else if (exp_hit) begin m_cnt = exp_len; m_seg = exp_seg; end
      else if (ret && m_cnt != 0) m_cnt = m_cnt - 1;
      instr_valid = 0; instr_bytes = 0; retire = 0; trap_b = 0;
      #1;
   endtask

   initial begin
      #150000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst = 1; instr_valid = 0; instr_bytes = 0; reg_rdata = 0; retire = 0; trap_b = 0;
      int_req = 3'b111; acc_long = 1; acc_ofs = 16'h1234; page_addr = 24'hABCDEF;
      m_cnt = 0; m_seg = 0;
      repeat (3) @(posedge clk);
      #1 rst = 0; #1;
      check_all("R10 reset");

      // sweep both forms, every length, several segments
      for (int f = 0; f < 2; f++)
         for (int len = 1; len <= 4; len++)
            for (int s = 0; s < 3; s++) begin
               logic [7:0] sg;
               logic [31:0] b;
               sg = 8'(8'h5A + s * 8'h37 + len);
               acc_ofs = 16'(16'h1000 * len + s);
               if (f == 0) begin
                  b = mk_reg(len, 4'(s + len));
                  instr_bytes = b; #1;
                  cmp("R1 src_reg", 32'(src_reg), 32'(s + len));
                  step(1, b, {8'hEE, sg}, 0, 0, 1, len, sg);
                  check_all("R1 R3 load");
               end else begin
                  b = mk_imm(len, sg);
                  step(1, b, 16'hFF00, 0, 0, 1, len, sg);
                  check_all("R2 R3 load");
               end
               for (int k = 0; k < len; k++) begin
                  step(0, 0, 0, 0, 0, 0, 0, 0);
                  check_all("R4 hold");
                  step(0, 0, 0, 1, 0, 0, 0, 0);
                  check_all("R4 retire");
               end
               cmp("R4 released", 32'(seq_active), 0);
            end

      // trap B mid sequence
      step(1, mk_imm(4, 8'h33), 0, 0, 0, 1, 4, 8'h33);
      step(0, 0, 0, 1, 0, 0, 0, 0);
      check_all("R8 before");
      step(0, 0, 0, 0, 1, 0, 0, 0);
      check_all("R8 abort");
      cmp("R8 abort off", 32'(seq_active), 0);
      // trap B in same cycle as decode
      step(1, mk_imm(3, 8'h44), 0, 0, 1, 1, 3, 8'h44);
      check_all("R8 same cycle");

      // reload while active, with retire in the same cycle
      step(1, mk_reg(2, 4'h3), 16'h0011, 0, 0, 1, 2, 8'h11);
      step(1, mk_imm(3, 8'h77), 0, 1, 0, 1, 3, 8'h77);
      check_all("R9 reload");
      cmp("R9 seg", 32'(data_addr[23:16]), 32'h77);
      for (int k = 0; k < 3; k++) begin
         check_all("R9 count");
         step(0, 0, 0, 1, 0, 0, 0, 0);
      end
      check_all("R9 end");

      // malformed encodings are ignored
      step(1, 32'h0000_A0DC ^ 32'h0000_4000, 16'h0099, 0, 0, 0, 0, 0);
      check_all("R2 bad tag");
      step(1, {8'h01, 8'h22, 8'hA0, 8'hD7}, 0, 0, 0, 0, 0, 0);
      check_all("R2 bad byte3");
      step(1, {8'h00, 8'h22, 8'hA5, 8'hD7}, 0, 0, 0, 0, 0, 0);
      check_all("R2 bad reg field");
      step(1, {8'h00, 8'h22, 8'hA0, 8'hD5}, 0, 0, 0, 0, 0, 0);
      check_all("R2 bad opcode");
      // strobe low with valid bytes
      step(0, mk_imm(2, 8'h55), 0, 0, 0, 0, 0, 0);
      check_all("R2 no strobe");

      // short access keeps page address during sequence
      step(1, mk_imm(1, 8'h66), 0, 0, 0, 1, 1, 8'h66);
      acc_long = 0; #1;
      cmp("R5 short access", 32'(data_addr), {8'h00, page_addr});
      acc_long = 1; #1;

      // reset mid sequence
      rst = 1;
      @(posedge clk); #1;
      rst = 0; m_cnt = 0; #1;
      check_all("R10 mid reset");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule